// File: doc/BRIEF.md
# Bus Target with Persistent Register Pointer

This block is the serial-bus front end of an eight-bit port expander. It watches an oversampled two-wire bus (clock line and data line), answers to one seven-bit target address and presents a small register access port to the register bank next to it. The bank itself lives outside the block. The block drives the data line only through an open-drain enable: when the enable is high the line is pulled low, and otherwise the line is released.

The address has a fixed upper nibble, set by a parameter whose default is `4'b0100`. The three low bits come from strap inputs, so eight of these targets can share one bus. In a write, the first byte after the address is a command byte. Its two low bits load a register pointer. Every further byte of that write goes to the pointed register, and the pointer does not advance. A read streams the pointed register for as long as the master acknowledges. The pointer keeps its value across STOP and START, so repeated reads return the same register until a new command byte arrives.

Top module: `gpx_i2c_target`

## Requirements
- R1: The target drives the data line low during the ninth clock of the address byte only when the seven address bits equal `{ADDR_FIXED, strap_i}`. On a mismatch it leaves the line released until the next START or STOP.
- R2: In a write, the first byte after the address is acknowledged and its bits [1:0] load `reg_ptr`.
- R3: Each later byte of a write is acknowledged. It produces exactly one `reg_wr_en` pulse of one clock cycle, with `reg_wr_data` equal to the byte, and `reg_ptr` stays unchanged (no auto-increment).
- R4: A command byte with a value of 4 to 255 is acknowledged and its bits [1:0] still load `reg_ptr`. The data bytes that follow it are acknowledged but raise no `reg_wr_en`.
- R5: In a read, each byte is `reg_rd_data` shifted out MSB first. It is sampled for the pointed register at the start of that byte.
- R6: `reg_ptr` holds its value across STOP and START. Reads with no new command byte keep returning the same register.
- R7: A master acknowledge (data line low on the ninth clock) makes the target send another byte of the same register. A master not-acknowledge makes it release the line and stay silent on further clocks until START or STOP.
- R8: A STOP at any point, including in the middle of a read, releases the data line and returns the target to idle. A repeated START restarts address matching.
- R9: After reset, `reg_ptr` is 0, `reg_wr_en` is 0 and the data line is released.
- R10: The least significant bit of the address byte selects the direction: 1 is a read and 0 is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| strap_i | input | 3 | Low three address bits |
| reg_ptr | output | 2 | Register pointer set by the command byte |
| reg_wr_en | output | 1 | One-cycle write strobe for the pointed register |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Contents of the pointed register |

## Verification
The assertions assume the bus inputs are oversampled by a wide margin. They also assume the data line changes only while the clock line is low, except for START and STOP, so that STOP and START are the only data edges seen with the clock high. They further assume command and data strobes arrive many system cycles apart, as whole bus bytes force. The bench master holds every bus phase for eight system clocks, so each bus bit takes 32 cycles. It changes the data line only in the middle of a clock-low phase and samples in the middle of the clock-high phase. It forms the line as the wired AND of its own drive and the target's enable.

// File: rtl/gpx_i2c_pkg.sv
// Shared types for the bus target: the engine states and the bundle of
// bus events that the synchroniser hands to the engine.
package gpx_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/gpx_bus_sync.sv
// Brings the two bus lines into the clock domain and derives edge and
// condition events from them.
// Assumes: the system clock is at least 16x the bus clock, and SYNC_STAGES >= 2.
module gpx_bus_sync
    import gpx_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LINES = 2;
    localparam int SCL_IDX = 1;
    localparam int SDA_IDX = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        // Flop chain per line; it resets to the idle-high bus level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[SYNC_STAGES-1];
    end

    // Previous synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    // Edge and condition decode.
    always_comb begin
        evt.scl_rise = cur[SCL_IDX] & ~prev[SCL_IDX];
        evt.scl_fall = ~cur[SCL_IDX] & prev[SCL_IDX];
        evt.start    = cur[SCL_IDX] & prev[SCL_IDX] & prev[SDA_IDX] & ~cur[SDA_IDX];
        evt.stop     = cur[SCL_IDX] & prev[SCL_IDX] & ~prev[SDA_IDX] & cur[SDA_IDX];
        evt.sda      = cur[SDA_IDX];
    end

endmodule

// File: rtl/gpx_target_fsm.sv
// Bus engine. It shifts bytes in and out, matches the address, drives the
// acknowledge and the read bits, and pulses cmd_load or data_load when a
// write byte completes.
// Assumes: bus events come from gpx_bus_sync, and rd_data is valid whenever
// a read byte begins.
module gpx_target_fsm
    import gpx_i2c_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         STRAP_W    = 3,
    parameter int         FIX_W      = 4,
    parameter logic [FIX_W-1:0] ADDR_FIXED = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_evt_t           evt,
    input  logic [STRAP_W-1:0] strap,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               cmd_load,
    output logic               data_load,
    output logic [DATA_W-1:0]  byte_q
);
    localparam int ADDR_W = FIX_W + STRAP_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    tgt_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  sr;
    logic [DATA_W-1:0]  tx;
    logic               rw;
    logic               mnack;
    logic [ADDR_W-1:0]  own_addr;

    assign own_addr = {ADDR_FIXED, strap};
    assign byte_q   = sr;

    // Main sequencer; START and STOP override any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sr        <= '0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            rw        <= 1'b0;
            mnack     <= 1'b0;
            cmd_load  <= 1'b0;
            data_load <= 1'b0;
        end else begin
            cmd_load  <= 1'b0;
            data_load <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (evt.scl_rise && cnt != CNT_FULL) begin
                            sr  <= {sr[DATA_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == CNT_FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (sr[DATA_W-1:DATA_W-ADDR_W] == own_addr) begin
                                    state  <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                    rw     <= sr[0];
                                end else begin
                                    state  <= ST_WAIT;
                                end
                            end else if (state == ST_CMD) begin
                                state    <= ST_CMD_ACK;
                                sda_oe   <= 1'b1;
                                cmd_load <= 1'b1;
                            end else begin
                                state     <= ST_WDATA_ACK;
                                sda_oe    <= 1'b1;
                                data_load <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[DATA_W-2:0], 1'b0};
                                sda_oe <= ~tx[DATA_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mnack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (!mnack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe); // R8
    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT |-> !sda_oe); // R7
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!sda_oe && state == ST_IDLE)); // R8
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.start && !evt.stop) |=> (state == ST_ADDR && !sda_oe)); // R8
    AST_ONE_LOAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_load && data_load)); // R3

endmodule

// File: rtl/gpx_cmd_ptr.sv
// Holds the register pointer and the command-valid flag, and turns data
// bytes into write strobes for the register bank.
// Assumes: cmd_load and data_load are single-cycle pulses from the engine.
module gpx_cmd_ptr #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic              data_load,
    input  logic [DATA_W-1:0] byte_in,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    localparam int HI_W = DATA_W - PTR_W;

    logic cmd_ok;

    // Pointer capture and write strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            cmd_ok  <= 1'b1;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (cmd_load) begin
                ptr    <= byte_in[PTR_W-1:0];
                cmd_ok <= (byte_in[DATA_W-1:PTR_W] == HI_W'(0));
            end
            if (data_load && cmd_ok) begin
                wr_en   <= 1'b1;
                wr_data <= byte_in;
            end
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> $stable(ptr)); // R6
    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(data_load)); // R4

endmodule

// File: rtl/gpx_i2c_target.sv
// Top of the bus target for the port expander. It joins the line
// synchroniser, the bus engine and the pointer/strobe stage.
// Assumes: the register bank drives reg_rd_data from reg_ptr without delay.
module gpx_i2c_target
    import gpx_i2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         DATA_W      = 8,
    parameter int         PTR_W       = 2,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] ADDR_FIXED  = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [PTR_W-1:0]   reg_ptr,
    output logic               reg_wr_en,
    output logic [DATA_W-1:0]  reg_wr_data,
    input  logic [DATA_W-1:0]  reg_rd_data
);
    bus_evt_t          evt;
    logic              cmd_load;
    logic              data_load;
    logic [DATA_W-1:0] byte_q;

    gpx_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    gpx_target_fsm #(
        .DATA_W     (DATA_W),
        .STRAP_W    (STRAP_W),
        .FIX_W      (4),
        .ADDR_FIXED (ADDR_FIXED)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .strap     (strap_i),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe),
        .cmd_load  (cmd_load),
        .data_load (data_load),
        .byte_q    (byte_q)
    );

    gpx_cmd_ptr #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_load  (cmd_load),
        .data_load (data_load),
        .byte_in   (byte_q),
        .ptr       (reg_ptr),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data)
    );

endmodule

// File: tb/gpx_i2c_target_tb_top.sv
module gpx_i2c_target_tb_top;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] OWN = {4'b0100, STRAP};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] reg_ptr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic [7:0] regfile [4];

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cycles = 0;

    logic [7:0] exp_regs [4];
    logic [1:0] exp_ptr;
    bit         exp_ok;
    int         exp_wr;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = regfile[reg_ptr];

    gpx_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(STRAP), .reg_ptr(reg_ptr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(8'h5A ^ (i * 8'h47));
    endfunction

    // Register bank beside the target; also counts strobe cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) regfile[i] <= init_val(i);
        end else if (reg_wr_en) begin
            regfile[reg_ptr] <= reg_wr_data;
            wr_cycles <= wr_cycles + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        s = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(nack, s);
    endtask

    task automatic model_cmd(logic [7:0] c);
        exp_ptr = c[1:0];
        exp_ok  = (c < 8'd4);
    endtask

    task automatic model_data(logic [7:0] d);
        if (exp_ok) begin
            exp_regs[exp_ptr] = d;
            exp_wr++;
        end
    endtask

    task automatic check_state(string tag);
        chk({tag, " R2 pointer"}, reg_ptr, exp_ptr);
        chk({tag, " R3 single-cycle strobes"}, wr_cycles, exp_wr);
        for (int i = 0; i < 4; i++) chk({tag, " R4 register contents"}, regfile[i], exp_regs[i]);
        chk({tag, " R8 released after stop"}, sda_oe, 0);
    endtask

    task automatic wr_txn(logic [6:0] addr, logic [7:0] cmd, int n, logic [7:0] d0);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte({addr, 1'b0}, ack);
        chk("R1 address acknowledge", ack, addr == OWN);
        if (addr == OWN) begin
            send_byte(cmd, ack);
            chk("R2 command acknowledge", ack, 1);
            model_cmd(cmd);
            for (int i = 0; i < n; i++) begin
                d = (i == 0) ? d0 : 8'($urandom);
                send_byte(d, ack);
                chk("R3 data acknowledge", ack, 1);
                model_data(d);
            end
        end else begin
            send_byte(cmd, ack);
            chk("R1 silent after mismatch", ack, 0);
        end
        bus_stop();
        check_state("write");
    endtask

    task automatic rd_txn(int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk("R10 read address acknowledge", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk("R5 R7 read byte", b, exp_regs[exp_ptr]);
        end
        bus_stop();
        check_state("read");
    endtask

    initial begin
        bit ack;
        logic s;
        logic [7:0] b;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) exp_regs[i] = init_val(i);
        exp_ptr = 2'd0; exp_ok = 1'b1; exp_wr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R9 reset pointer", reg_ptr, 0);
        chk("R9 reset strobe", reg_wr_en, 0);
        chk("R9 reset line released", sda_oe, 0);

        rd_txn(1);                              // R9 reads register 0 with no command
        wr_txn(OWN, 8'h02, 1, 8'h3C);           // R2 R3
        rd_txn(3);                              // R5 R7
        wr_txn(OWN, 8'h07, 2, 8'h11);           // R4 bad command
        rd_txn(1);                              // R6 persists
        wr_txn({4'b0100, 3'b100}, 8'h00, 0, 8'h00); // R1 strap mismatch
        wr_txn(7'h55, 8'h01, 0, 8'h00);         // R1 fixed bits mismatch

        // R7: after master NACK the target stays silent on extra clocks.
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        recv_byte(1'b1, b);
        chk("R7 byte before nack", b, exp_regs[exp_ptr]);
        for (int i = 0; i < 3; i++) begin
            clock_bit(1'b1, s);
            chk("R7 silent after nack", s, 1);
        end
        bus_stop();

        // R8: STOP in the middle of a read, with the next bit high.
        wr_txn(OWN, 8'h01, 1, 8'hC3);
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk("R8 byte before mid-read stop", b, 8'hC3);
        bus_stop();
        chk("R8 released after mid-read stop", sda_oe, 0);
        rd_txn(1);

        // R8: repeated START from write into read.
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h00, ack);
        chk("R2 command before repeated start", ack, 1);
        model_cmd(8'h00);
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk("R8 address after repeated start", ack, 1);
        recv_byte(1'b1, b);
        chk("R8 data after repeated start", b, exp_regs[0]);
        bus_stop();
        check_state("restart");

        for (int it = 0; it < 40; it++) begin
            int kind = int'($urandom % 5);
            if (kind < 2) begin
                logic [7:0] c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
                wr_txn(OWN, c, int'($urandom % 4), 8'($urandom));
            end else if (kind < 4) begin
                rd_txn(1 + int'($urandom % 3));
            end else begin
                logic [6:0] a = OWN ^ 7'(1 << ($urandom % 7));
                wr_txn(a, 8'($urandom), 0, 8'h00);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule